// File: doc/BRIEF.md
# Four-Way Address Translation Buffer with Address-Space Tags

This block turns a 16-bit virtual address into a 22-bit physical address using sixteen cached translations. The translations are arranged as four sets of four ways. A page is 2 KB, so the low 11 address bits pass through unchanged as the page offset, and the upper 5 bits form the virtual page number. Each translation carries a 5-bit address-space tag and a global flag. A hit needs a matching tag, unless the global flag is set. Each translation also carries a valid bit, a modified bit, an uncached bit and a user-access bit.

A lookup is presented for one cycle and answered one cycle later. The answer carries a hit flag, the physical address, a 2-bit fault code and the uncached bit, which is passed through. When paging is off, the address goes through untranslated.

Privileged software loads a translation by presenting a 16-bit tag word and a 16-bit frame word on the load port. The set comes from the page number in the tag word. The way is either given explicitly or taken from a per-set round-robin pointer. Walking page tables and any cache reaction to the uncached bit are left to the surrounding logic.

Top module: `tlb_xlate`

## Requirements
- R1: After reset no response is signalled, and every stored translation is invalid, so any paged lookup misses.
- R2: With paging_en low, a lookup answers with hit=1, physical address = virtual address zero-extended to 22 bits, fault code 0 and uncached=0.
- R3: The set is selected by virtual address bits 12:11 (the two low page-number bits), and the whole 5-bit page number is compared. A stored page in the same set with a different page number does not hit.
- R4: A translation whose valid bit (frame word bit 5) is 0 never hits.
- R5: A hit requires the lookup's address-space tag to equal tag-word bits 15:11, unless the global flag (tag-word bit 5) is 1, in which case any tag hits.
- R6: On a paged hit, the physical address is {frame word bits 15:6, virtual bits 10:0} zero-extended to 22 bits, and rsp_uncache equals frame word bit 3.
- R7: A user-mode lookup (lk_user=1) that hits a translation whose user bit (frame word bit 2) is 0 reports fault code 2. This takes precedence over code 3.
- R8: A write lookup that hits a translation whose modified bit (frame word bit 4) is 0 reports fault code 3, unless code 2 applies.
- R9: A paged lookup that matches no way reports hit=0 and fault code 1. Code 0 means no fault.
- R10: A load with wr_auto=0 writes the way given by wr_way in the set named by tag-word bits 7:6, replacing whatever was there.
- R11: A load with wr_auto=1 writes the way held by that set's round-robin pointer and then advances the pointer (0,1,2,3,0...). Explicit-way loads leave the pointer unchanged, and each set has its own pointer.
- R12: When several ways in the selected set match, the lowest-numbered way supplies the translation.
- R13: rsp_valid is high exactly in the cycle after a cycle with lk_valid high. A lookup in the same cycle as a load sees the contents from before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| paging_en | input | 1 | Translation enable; low means pass-through |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vaddr | input | 16 | Virtual address to translate |
| lk_asid | input | 5 | Current address-space tag |
| lk_user | input | 1 | 1 = user-mode access |
| lk_write | input | 1 | 1 = store access |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_hit | output | 1 | Translation found (or paging off) |
| rsp_paddr | output | 22 | Physical address |
| rsp_fault | output | 2 | 0 none, 1 miss, 2 protection, 3 modify |
| rsp_uncache | output | 1 | Uncached bit of the hit translation |
| wr_en | input | 1 | Load a translation |
| wr_auto | input | 1 | 1 = way from round-robin pointer |
| wr_way | input | 2 | Explicit way when wr_auto is 0 |
| wr_hi | input | 16 | Tag word: tag 15:11, page 10:6, global 5 |
| wr_lo | input | 16 | Frame word: frame 15:6, valid 5, modified 4, uncached 3, user 2 |

## Verification
A corrupted round-robin pointer shows up at the ports only indirectly. It surfaces on the lookup after the next automatic load, when an older page that should have survived misses, or one that should have been evicted still hits. The bench therefore fills a set completely and probes every victim. A wrong stored field, or a bad priority choice among duplicate matches, changes rsp_paddr, rsp_fault or rsp_uncache on the very next response, one cycle after the lookup. Each such case is probed right after the load that sets it up.

// File: rtl/tlb_pkg.sv
// Shared field layout, entry type and fault codes for the translation buffer.
// Assumes a 16-bit virtual address with 2 KB pages.
package tlb_pkg;
    localparam int VA_W   = 16;
    localparam int OFF_W  = 11;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int ASID_W = 5;
    localparam int PFN_W  = 10;
    localparam int PA_W   = 22;
    localparam int WORD_W = 16;

    // Software-visible bit positions inside the two load words.
    localparam int HI_ASID_LSB = 11;
    localparam int HI_VPN_LSB  = 6;
    localparam int HI_GLB_BIT  = 5;
    localparam int LO_PFN_LSB  = 6;
    localparam int LO_VAL_BIT  = 5;
    localparam int LO_DRT_BIT  = 4;
    localparam int LO_UNC_BIT  = 3;
    localparam int LO_USR_BIT  = 2;

    typedef struct packed {
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic              glob;
        logic [PFN_W-1:0]  pfn;
        logic              valid;
        logic              dirty;
        logic              uncache;
        logic              user;
    } tlb_entry_t;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_MISS = 2'd1,
        FLT_PROT = 2'd2,
        FLT_MOD  = 2'd3
    } fault_e;

    // Gathers the used fields of the two load words into one entry.
    function automatic tlb_entry_t unpack_words(input logic [WORD_W-1:0] hi,
                                                input logic [WORD_W-1:0] lo);
        tlb_entry_t e;
        e.asid    = hi[HI_ASID_LSB +: ASID_W];
        e.vpn     = hi[HI_VPN_LSB +: VPN_W];
        e.glob    = hi[HI_GLB_BIT];
        e.pfn     = lo[LO_PFN_LSB +: PFN_W];
        e.valid   = lo[LO_VAL_BIT];
        e.dirty   = lo[LO_DRT_BIT];
        e.uncache = lo[LO_UNC_BIT];
        e.user    = lo[LO_USR_BIT];
        return e;
    endfunction
endpackage

// File: rtl/tlb_entry_store.sv
// Entry storage with one round-robin victim pointer per set.
// Assumes NUM_WAYS is a power of two >= 2, so the pointer wraps naturally.
// The read port is combinational; a write becomes visible the cycle after.
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter int NUM_SETS = 4,
    parameter int NUM_WAYS = 4,
    localparam int SET_W = $clog2(NUM_SETS),
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        wr_auto,
    input  logic [WAY_W-1:0]            wr_way,
    input  tlb_entry_t                  wr_entry,
    input  logic [SET_W-1:0]            rd_set,
    output tlb_entry_t [NUM_WAYS-1:0]   rd_ways
);
    tlb_entry_t       mem [NUM_SETS][NUM_WAYS];
    logic [WAY_W-1:0] rr  [NUM_SETS];
    logic [SET_W-1:0] wr_set;
    logic [WAY_W-1:0] tgt_way;

    // Pick the target set from the page number and the way from port or pointer.
    always_comb begin
        wr_set  = wr_entry.vpn[SET_W-1:0];
        tgt_way = wr_auto ? rr[wr_set] : wr_way;
    end

    // Store the entry and advance the pointer on automatic loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                rr[s] <= '0;
                for (int w = 0; w < NUM_WAYS; w++) mem[s][w] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_set][tgt_way] <= wr_entry;
            if (wr_auto) rr[wr_set] <= rr[wr_set] + 1'b1;
        end
    end

    // Present every way of the addressed set.
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_rd
        assign rd_ways[w] = mem[rd_set][w];
    end

    // R11: automatic load advances its set's pointer by one.
    a_r11_rr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_auto) |=> rr[$past(wr_set)] == WAY_W'($past(rr[wr_set]) + 1'b1));
    // R11: explicit load leaves the pointer alone.
    a_r11_rr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_auto) |=> rr[$past(wr_set)] == $past(rr[wr_set]));
    // R10: the loaded entry is present in the target slot afterwards.
    a_r10_stored: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem[$past(wr_set)][$past(tgt_way)] == $past(wr_entry));
endmodule

// File: rtl/tlb_way_match.sv
// Parallel tag compare across the ways of one set, with a lowest-way-wins pick.
// Purely combinational; assumes the caller supplies the set already indexed.
module tlb_way_match
    import tlb_pkg::*;
#(
    parameter int NUM_WAYS = 4
) (
    input  tlb_entry_t [NUM_WAYS-1:0] ways,
    input  logic [VPN_W-1:0]          vpn,
    input  logic [ASID_W-1:0]         asid,
    output logic                      hit,
    output tlb_entry_t                hit_entry
);
    logic [NUM_WAYS-1:0] match;
    logic [NUM_WAYS-1:0] sel_oh;

    // One comparator per way: valid, page number, and tag or global.
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign match[w] = ways[w].valid && (ways[w].vpn == vpn) &&
                          (ways[w].glob || (ways[w].asid == asid));
    end

    // Priority pick: scan downward so the lowest matching way is left selected.
    always_comb begin
        sel_oh    = '0;
        hit_entry = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                sel_oh    = '0;
                sel_oh[w] = 1'b1;
                hit_entry = ways[w];
            end
        end
        hit = |match;
    end

    // R12: at most one way selected, and no lower way also matches.
    always_comb begin
        a_r12_onehot: assert ($onehot0(sel_oh));
        a_r12_lowest: assert ((match & (sel_oh - 1'b1)) == '0);
    end
endmodule

// File: rtl/tlb_xlate.sv
// Top of the translation buffer: indexes the set, runs the compare, applies
// permission checks and registers a one-cycle-latency response. Loads and
// lookups may share a cycle; the lookup sees pre-load contents.
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int NUM_SETS = 4,
    parameter int NUM_WAYS = 4,
    localparam int SET_W = $clog2(NUM_SETS),
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              paging_en,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_user,
    input  logic              lk_write,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [1:0]        rsp_fault,
    output logic              rsp_uncache,
    input  logic              wr_en,
    input  logic              wr_auto,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [WORD_W-1:0] wr_hi,
    input  logic [WORD_W-1:0] wr_lo
);
    tlb_entry_t [NUM_WAYS-1:0] set_ways;
    tlb_entry_t                m_entry;
    tlb_entry_t                wr_entry;
    logic                      m_hit;
    logic [VPN_W-1:0]          lk_vpn;
    logic                      nx_hit, nx_unc;
    logic [PA_W-1:0]           nx_pa;
    fault_e                    nx_flt;
    logic                      unused_bits;

    assign wr_entry    = unpack_words(wr_hi, wr_lo);
    assign lk_vpn      = lk_vaddr[VA_W-1:OFF_W];
    assign unused_bits = ^{wr_hi[HI_GLB_BIT-1:0], wr_lo[LO_USR_BIT-1:0],
                           m_entry.asid, m_entry.vpn, m_entry.glob};

    tlb_entry_store #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_auto(wr_auto),
        .wr_way(wr_way), .wr_entry(wr_entry),
        .rd_set(lk_vpn[SET_W-1:0]), .rd_ways(set_ways)
    );

    tlb_way_match #(.NUM_WAYS(NUM_WAYS)) u_match (
        .ways(set_ways), .vpn(lk_vpn), .asid(lk_asid),
        .hit(m_hit), .hit_entry(m_entry)
    );

    // Form the answer: pass-through, miss, or hit with permission checks.
    always_comb begin
        nx_hit = 1'b0;
        nx_pa  = '0;
        nx_unc = 1'b0;
        nx_flt = FLT_MISS;
        if (!paging_en) begin
            nx_hit = 1'b1;
            nx_pa  = PA_W'(lk_vaddr);
            nx_flt = FLT_NONE;
        end else if (m_hit) begin
            nx_hit = 1'b1;
            nx_pa  = PA_W'({m_entry.pfn, lk_vaddr[OFF_W-1:0]});
            nx_unc = m_entry.uncache;
            if (lk_user && !m_entry.user)       nx_flt = FLT_PROT;
            else if (lk_write && !m_entry.dirty) nx_flt = FLT_MOD;
            else                                 nx_flt = FLT_NONE;
        end
    end

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_paddr   <= '0;
            rsp_fault   <= FLT_NONE;
            rsp_uncache <= 1'b0;
        end else begin
            rsp_valid <= lk_valid;
            if (lk_valid) begin
                rsp_hit     <= nx_hit;
                rsp_paddr   <= nx_pa;
                rsp_fault   <= nx_flt;
                rsp_uncache <= nx_unc;
            end
        end
    end

    // R13: response strobe follows the request strobe by exactly one cycle.
    a_r13_latency: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    a_r13_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);
    // R2: paging off gives an untranslated, fault-free answer.
    a_r2_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !paging_en) |=> (rsp_hit && rsp_fault == FLT_NONE &&
                                      rsp_paddr == PA_W'($past(lk_vaddr))));
    // R9: a miss always carries the miss code, and a clean code implies a hit.
    a_r9_miss_code: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> rsp_fault == FLT_MISS);
    a_r9_none_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_NONE) |-> rsp_hit);
    // R6: the page offset is never altered on a hit.
    a_r6_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0]));
endmodule

// File: tb/tlb_xlate_test.sv
`timescale 1ns/1ps
module tlb_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        paging_en, lk_valid, lk_user, lk_write;
    logic [15:0] lk_vaddr;
    logic [4:0]  lk_asid;
    logic        rsp_valid, rsp_hit, rsp_uncache;
    logic [21:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        wr_en, wr_auto;
    logic [1:0]  wr_way;
    logic [15:0] wr_hi, wr_lo;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    tlb_xlate uut (
        .clk(clk), .rst_n(rst_n), .paging_en(paging_en), .lk_valid(lk_valid),
        .lk_vaddr(lk_vaddr), .lk_asid(lk_asid), .lk_user(lk_user),
        .lk_write(lk_write), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_uncache(rsp_uncache),
        .wr_en(wr_en), .wr_auto(wr_auto), .wr_way(wr_way),
        .wr_hi(wr_hi), .wr_lo(wr_lo)
    );

    function automatic logic [15:0] mk_hi(input logic [4:0] asid,
                                          input logic [4:0] vpn, input logic g);
        return {asid, vpn, g, 5'b0};
    endfunction

    function automatic logic [15:0] mk_lo(input logic [9:0] pfn, input logic v,
                                          input logic d, input logic uc, input logic u);
        return {pfn, v, d, uc, u, 2'b0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input logic auto, input logic [1:0] way,
                        input logic [15:0] hi, input logic [15:0] lo);
        @(negedge clk);
        wr_en = 1'b1; wr_auto = auto; wr_way = way; wr_hi = hi; wr_lo = lo;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Issue one lookup and sample the response one cycle later.
    task automatic lookup(input logic [15:0] va, input logic [4:0] asid,
                          input logic user, input logic wr, input logic pe);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_asid = asid;
        lk_user = user; lk_write = wr; paging_en = pe;
        @(negedge clk);
        lk_valid = 1'b0;
        check("R13 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    endtask

    function automatic logic [21:0] pa(input logic [9:0] pfn, input logic [15:0] va);
        return {1'b0, pfn, va[10:0]};
    endfunction

    task automatic t_reset;
        check("R1 rsp_valid after reset", {31'b0, rsp_valid}, 0);
        lookup({5'd5, 11'h0}, 5'd0, 1'b0, 1'b0, 1'b1);
        check("R1 empty miss", {31'b0, rsp_hit}, 0);
        check("R9 miss code", {30'b0, rsp_fault}, 1);
        @(negedge clk);
        check("R13 no strobe without request", {31'b0, rsp_valid}, 0);
    endtask

    task automatic t_passthru;
        lookup(16'hBEEF, 5'd9, 1'b1, 1'b1, 1'b0);
        check("R2 hit", {31'b0, rsp_hit}, 1);
        check("R2 paddr", {10'b0, rsp_paddr}, 32'h0000BEEF);
        check("R2 fault", {30'b0, rsp_fault}, 0);
        check("R2 uncache", {31'b0, rsp_uncache}, 0);
    endtask

    task automatic t_basic_hit;
        load(1'b0, 2'd1, mk_hi(5'd3, 5'd5, 1'b0), mk_lo(10'h2A5, 1, 1, 1, 1));
        lookup({5'd5, 11'h123}, 5'd3, 1'b1, 1'b1, 1'b1);
        check("R6 hit", {31'b0, rsp_hit}, 1);
        check("R6 paddr", {10'b0, rsp_paddr}, {10'b0, pa(10'h2A5, {5'd5, 11'h123})});
        check("R6 uncache", {31'b0, rsp_uncache}, 1);
        check("R6 fault none", {30'b0, rsp_fault}, 0);
        // Same set (low page bits 01) but different page number.
        lookup({5'd9, 11'h123}, 5'd3, 1'b0, 1'b0, 1'b1);
        check("R3 full tag compare", {31'b0, rsp_hit}, 0);
    endtask

    task automatic t_asid;
        lookup({5'd5, 11'h7}, 5'd4, 1'b0, 1'b0, 1'b1);
        check("R5 tag mismatch misses", {31'b0, rsp_hit}, 0);
        load(1'b0, 2'd0, mk_hi(5'd1, 5'd8, 1'b1), mk_lo(10'h11, 1, 1, 0, 1));
        lookup({5'd8, 11'h40}, 5'd30, 1'b0, 1'b0, 1'b1);
        check("R5 global hits any tag", {31'b0, rsp_hit}, 1);
        check("R5 global paddr", {10'b0, rsp_paddr}, {10'b0, pa(10'h11, {5'd8, 11'h40})});
    endtask

    task automatic t_valid;
        load(1'b0, 2'd3, mk_hi(5'd0, 5'd2, 1'b1), mk_lo(10'h3FF, 0, 1, 0, 1));
        lookup({5'd2, 11'h0}, 5'd0, 1'b0, 1'b0, 1'b1);
        check("R4 invalid never hits", {31'b0, rsp_hit}, 0);
    endtask

    task automatic t_perm;
        load(1'b0, 2'd2, mk_hi(5'd2, 5'd10, 1'b0), mk_lo(10'h55, 1, 0, 0, 0));
        lookup({5'd10, 11'h1}, 5'd2, 1'b1, 1'b0, 1'b1);
        check("R7 user fault", {30'b0, rsp_fault}, 2);
        lookup({5'd10, 11'h1}, 5'd2, 1'b1, 1'b1, 1'b1);
        check("R7 protection beats modify", {30'b0, rsp_fault}, 2);
        lookup({5'd10, 11'h1}, 5'd2, 1'b0, 1'b1, 1'b1);
        check("R8 modify fault", {30'b0, rsp_fault}, 3);
        lookup({5'd10, 11'h1}, 5'd2, 1'b0, 1'b0, 1'b1);
        check("R8 supervisor read clean", {30'b0, rsp_fault}, 0);
    endtask

    task automatic t_overwrite;
        load(1'b0, 2'd1, mk_hi(5'd3, 5'd5, 1'b0), mk_lo(10'h0C3, 1, 1, 0, 1));
        lookup({5'd5, 11'h3}, 5'd3, 1'b0, 1'b0, 1'b1);
        check("R10 explicit overwrite", {10'b0, rsp_paddr}, {10'b0, pa(10'h0C3, {5'd5, 11'h3})});
    endtask

    task automatic t_round_robin;
        // Set 3 pages: 3, 7, 11, 15 fill ways 0..3 in turn.
        for (int i = 0; i < 4; i++)
            load(1'b1, 2'd0, mk_hi(5'd0, 5'(4 * i + 3), 1'b1), mk_lo(10'(i + 1), 1, 1, 0, 1));
        for (int i = 0; i < 4; i++) begin
            lookup({5'(4 * i + 3), 11'h0}, 5'd0, 1'b0, 1'b0, 1'b1);
            check("R11 filled way hits", {10'b0, rsp_paddr}, {10'b0, pa(10'(i + 1), {5'(4 * i + 3), 11'h0})});
        end
        load(1'b1, 2'd0, mk_hi(5'd0, 5'd19, 1'b1), mk_lo(10'h20, 1, 1, 0, 1));
        lookup({5'd3, 11'h0}, 5'd0, 1'b0, 1'b0, 1'b1);
        check("R11 wrap evicts way 0", {31'b0, rsp_hit}, 0);
        // Explicit load to way 3 must not move the pointer (now at 1).
        load(1'b0, 2'd3, mk_hi(5'd0, 5'd23, 1'b1), mk_lo(10'h21, 1, 1, 0, 1));
        load(1'b1, 2'd0, mk_hi(5'd0, 5'd27, 1'b1), mk_lo(10'h22, 1, 1, 0, 1));
        lookup({5'd7, 11'h0}, 5'd0, 1'b0, 1'b0, 1'b1);
        check("R11 pointer held across explicit load", {31'b0, rsp_hit}, 0);
        lookup({5'd11, 11'h0}, 5'd0, 1'b0, 1'b0, 1'b1);
        check("R11 way 2 untouched", {31'b0, rsp_hit}, 1);
        // Set 2 pointer independent: first automatic load there lands in way 0.
        load(1'b0, 2'd1, mk_hi(5'd0, 5'd14, 1'b1), mk_lo(10'h30, 1, 1, 0, 1));
        load(1'b1, 2'd0, mk_hi(5'd0, 5'd18, 1'b1), mk_lo(10'h31, 1, 1, 0, 1));
        lookup({5'd14, 11'h0}, 5'd0, 1'b0, 1'b0, 1'b1);
        check("R11 per-set pointer", {31'b0, rsp_hit}, 1);
    endtask

    task automatic t_duplicates;
        load(1'b0, 2'd2, mk_hi(5'd6, 5'd6, 1'b0), mk_lo(10'h1B0, 1, 1, 0, 1));
        load(1'b0, 2'd3, mk_hi(5'd6, 5'd6, 1'b0), mk_lo(10'h1C0, 1, 1, 0, 1));
        load(1'b0, 2'd0, mk_hi(5'd6, 5'd6, 1'b0), mk_lo(10'h1A0, 1, 1, 0, 1));
        lookup({5'd6, 11'h5}, 5'd6, 1'b0, 1'b0, 1'b1);
        check("R12 lowest way wins", {10'b0, rsp_paddr}, {10'b0, pa(10'h1A0, {5'd6, 11'h5})});
        load(1'b0, 2'd0, mk_hi(5'd6, 5'd6, 1'b0), mk_lo(10'h1A0, 0, 1, 0, 1));
        lookup({5'd6, 11'h5}, 5'd6, 1'b0, 1'b0, 1'b1);
        check("R12 next lowest way", {10'b0, rsp_paddr}, {10'b0, pa(10'h1B0, {5'd6, 11'h5})});
    endtask

    task automatic t_same_cycle;
        // Load and lookup together: lookup sees the old (missing) state.
        @(negedge clk);
        wr_en = 1'b1; wr_auto = 1'b0; wr_way = 2'd0;
        wr_hi = mk_hi(5'd7, 5'd4, 1'b0); wr_lo = mk_lo(10'h77, 1, 1, 0, 1);
        lk_valid = 1'b1; lk_vaddr = {5'd4, 11'h9}; lk_asid = 5'd7; paging_en = 1'b1;
        lk_user = 1'b0; lk_write = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; lk_valid = 1'b0;
        check("R13 lookup sees pre-load contents", {31'b0, rsp_hit}, 0);
        lookup({5'd4, 11'h9}, 5'd7, 1'b0, 1'b0, 1'b1);
        check("R13 load visible next lookup", {31'b0, rsp_hit}, 1);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL R13 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; paging_en = 1'b0; lk_valid = 1'b0; lk_vaddr = '0;
        lk_asid = '0; lk_user = 1'b0; lk_write = 1'b0;
        wr_en = 1'b0; wr_auto = 1'b0; wr_way = '0; wr_hi = '0; wr_lo = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_passthru();
        t_basic_hit();
        t_asid();
        t_valid();
        t_perm();
        t_overwrite();
        t_round_robin();
        t_duplicates();
        t_same_cycle();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule